// File: doc/BRIEF.md
# Multi-line interrupt vector arbiter

This block gathers receive and transmit interrupt requests from a group of serial lines that share one device vector base. Each line raises or withdraws a request in either direction with one-cycle set and clear pulses. The arbiter keeps one pending bit per line and per direction, and drives one master request output for each direction. A master request is high while any line has a pending bit in that direction.

When the interrupt controller acknowledges, it says whether it is serving receive or transmit. The arbiter then picks the lowest-numbered line with a pending bit in that direction, and clears that bit. One cycle later it presents the vector for that line, together with a valid flag. The vector is the base, plus eight per line, plus four for a transmit request. If no line is pending in the chosen direction, the returned vector is zero.

The number of lines that take part is a parameter. Request pins of lines at or above that count are ignored.

Top module: `irq_vector_arbiter`

## Requirements
- R1: Out of reset no request is pending and both master requests and `vec_valid` are low. A set pulse on an active line makes that direction's master request high from the next cycle.
- R2: A clear pulse removes that line's pending bit in that direction. A master request falls only in the cycle after the last pending bit of its direction is removed.
- R3: An acknowledge with `ack_tx`=0 serves receive and with `ack_tx`=1 serves transmit. In either case the lowest-numbered line pending in that direction is chosen.
- R4: For a receive acknowledge the vector is `vec_base` + 8 × line. For a transmit acknowledge it is `vec_base` + 8 × line + 4. The base is the one present in the acknowledge cycle.
- R5: An acknowledge clears only the chosen line's bit in the chosen direction. Other lines and the other direction keep their pending bits.
- R6: An acknowledge when no line is pending in the chosen direction returns vector 0, still with `vec_valid` high.
- R7: A `line_rst` pulse on a line clears both of its pending bits. It also overrides a set pulse for that line in the same cycle.
- R8: If a set pulse and a clear pulse hit the same line and direction in one cycle, the set wins and the bit stays pending. The same holds when a set pulse meets the clearing done by an acknowledge.
- R9: `vec_valid` is high exactly in the cycle after an acknowledge cycle, and low in every other cycle.
- R10: Set pulses on lines numbered `NUM_LINES` or above never make a request pending, and such lines are never selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_set | input | MAX_LINES | Per-line receive request set pulses |
| rx_clr | input | MAX_LINES | Per-line receive request clear pulses |
| tx_set | input | MAX_LINES | Per-line transmit request set pulses |
| tx_clr | input | MAX_LINES | Per-line transmit request clear pulses |
| line_rst | input | MAX_LINES | Per-line reset, clears both directions |
| vec_base | input | VEC_W | Device vector base |
| ack | input | 1 | Acknowledge strobe, one cycle |
| ack_tx | input | 1 | Direction of the acknowledge: 0 receive, 1 transmit |
| rx_irq | output | 1 | Receive master request |
| tx_irq | output | 1 | Transmit master request |
| vec_valid | output | 1 | Vector valid, the cycle after an acknowledge |
| vec_out | output | VEC_W | Returned vector |

## Verification
The first pattern pends several receive lines and one transmit line, then drains them one acknowledge at a time. This shows whether the lowest line is chosen and whether the other direction is left alone. A second pattern sets every active line in both directions and drains them in turn, which exposes any ordering fault. Same-cycle collisions are driven for set against clear, set against acknowledge, and set against line reset, so the priority order is visible at the outputs. Empty acknowledges, pins of inactive lines and a change of base show the zero vector, the ignored lines and that the base is taken from the acknowledge cycle.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   // direction served by an acknowledge
   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } irqv_dir_e;

   // lowest-index search variants
   localparam int ENC_SCAN    = 0;
   localparam int ENC_ISOLATE = 1;

endpackage

// File: rtl/irqv_pend_bank.sv
module irqv_pend_bank #(
   parameter int MAX_LINES = 16,
   parameter int NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MAX_LINES-1:0] set_p,
   input  logic [MAX_LINES-1:0] clr_p,
   input  logic [MAX_LINES-1:0] kill_p,
   input  logic [MAX_LINES-1:0] ack_clr,
   output logic [MAX_LINES-1:0] pend,
   output logic                 any
);

   localparam logic [MAX_LINES-1:0] LIVE_MASK = {MAX_LINES{1'b1}} >> (MAX_LINES - NUM_LINES);

   logic [MAX_LINES-1:0] pend_nxt;

   // set beats clear and acknowledge; line reset beats everything
   always_comb begin
      pend_nxt = (pend & ~clr_p & ~ack_clr) | set_p;
      pend_nxt = pend_nxt & ~kill_p & LIVE_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_nxt;
   end

   assign any = |pend;

endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc
   import irqv_pkg::*;
#(
   parameter int N         = 16,
   parameter int IDX_W     = 4,
   parameter int ENC_STYLE = ENC_ISOLATE
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     onehot
);

   if (ENC_STYLE == ENC_SCAN) begin : g_scan
      // walk from the top down so the last hit is the lowest line
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               found = 1'b1;
               idx   = IDX_W'(i);
            end
         end
         onehot = found ? (N'(1) << idx) : '0;
      end
   end else begin : g_isolate
      // isolate lowest set bit, then OR together the index of that bit
      always_comb begin
         onehot = req & (~req + N'(1));
         found  = |req;
         idx    = '0;
         for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/irqv_vec_gen.sv
module irqv_vec_gen
   import irqv_pkg::*;
#(
   parameter int VEC_W  = 16,
   parameter int IDX_W  = 4,
   parameter int SHIFT  = 3,
   parameter int TX_OFF = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   input  irqv_dir_e        dir,
   input  logic             found_rx,
   input  logic [IDX_W-1:0] idx_rx,
   input  logic             found_tx,
   input  logic [IDX_W-1:0] idx_tx,
   input  logic [VEC_W-1:0] base,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_out
);

   logic             sel_found;
   logic [IDX_W-1:0] sel_idx;
   logic [VEC_W-1:0] line_off;
   logic [VEC_W-1:0] dir_off;
   logic [VEC_W-1:0] vec_nxt;

   always_comb begin
      sel_found = (dir == DIR_TX) ? found_tx : found_rx;
      sel_idx   = (dir == DIR_TX) ? idx_tx   : idx_rx;
      line_off  = VEC_W'(sel_idx) << SHIFT;
      dir_off   = (dir == DIR_TX) ? VEC_W'(TX_OFF) : '0;
      vec_nxt   = sel_found ? (base + line_off + dir_off) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         vec_valid <= ack;
         if (ack) vec_out <= vec_nxt;
      end
   end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
   import irqv_pkg::*;
#(
   parameter int MAX_LINES  = 16,
   parameter int NUM_LINES  = 16,
   parameter int VEC_W      = 16,
   parameter int LINE_SHIFT = 3,
   parameter int TX_OFFSET  = 4,
   parameter int ENC_STYLE  = ENC_ISOLATE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MAX_LINES-1:0] rx_set,
   input  logic [MAX_LINES-1:0] rx_clr,
   input  logic [MAX_LINES-1:0] tx_set,
   input  logic [MAX_LINES-1:0] tx_clr,
   input  logic [MAX_LINES-1:0] line_rst,
   input  logic [VEC_W-1:0]     vec_base,
   input  logic                 ack,
   input  logic                 ack_tx,
   output logic                 rx_irq,
   output logic                 tx_irq,
   output logic                 vec_valid,
   output logic [VEC_W-1:0]     vec_out
);

   localparam int IDX_W = $clog2(MAX_LINES);

   // elaboration-time parameter checks
   if (MAX_LINES < 2 || MAX_LINES > 16) begin : g_bad_max
      $error("MAX_LINES must lie in 2..16");
   end
   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_num
      $error("NUM_LINES must lie in 1..MAX_LINES");
   end
   if (TX_OFFSET < 1 || TX_OFFSET >= (1 << LINE_SHIFT)) begin : g_bad_off
      $error("TX_OFFSET must be nonzero and below the line stride");
   end
   if (VEC_W <= IDX_W + LINE_SHIFT) begin : g_bad_vw
      $error("VEC_W too narrow for line index and stride");
   end
   if (ENC_STYLE != ENC_SCAN && ENC_STYLE != ENC_ISOLATE) begin : g_bad_enc
      $error("unknown ENC_STYLE");
   end

   irqv_dir_e            dir;
   logic [MAX_LINES-1:0] pend_rx, pend_tx;
   logic [MAX_LINES-1:0] oh_rx, oh_tx;
   logic [MAX_LINES-1:0] aclr_rx, aclr_tx;
   logic [IDX_W-1:0]     idx_rx, idx_tx;
   logic                 found_rx, found_tx;

   assign dir     = irqv_dir_e'(ack_tx);
   assign aclr_rx = (ack && dir == DIR_RX) ? oh_rx : '0;
   assign aclr_tx = (ack && dir == DIR_TX) ? oh_tx : '0;

   irqv_pend_bank #(.MAX_LINES(MAX_LINES), .NUM_LINES(NUM_LINES)) u_bank_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_p   (rx_set),
      .clr_p   (rx_clr),
      .kill_p  (line_rst),
      .ack_clr (aclr_rx),
      .pend    (pend_rx),
      .any     (rx_irq)
   );

   irqv_pend_bank #(.MAX_LINES(MAX_LINES), .NUM_LINES(NUM_LINES)) u_bank_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_p   (tx_set),
      .clr_p   (tx_clr),
      .kill_p  (line_rst),
      .ack_clr (aclr_tx),
      .pend    (pend_tx),
      .any     (tx_irq)
   );

   irqv_prio_enc #(.N(MAX_LINES), .IDX_W(IDX_W), .ENC_STYLE(ENC_STYLE)) u_enc_rx (
      .req    (pend_rx),
      .found  (found_rx),
      .idx    (idx_rx),
      .onehot (oh_rx)
   );

   irqv_prio_enc #(.N(MAX_LINES), .IDX_W(IDX_W), .ENC_STYLE(ENC_STYLE)) u_enc_tx (
      .req    (pend_tx),
      .found  (found_tx),
      .idx    (idx_tx),
      .onehot (oh_tx)
   );

   irqv_vec_gen #(.VEC_W(VEC_W), .IDX_W(IDX_W), .SHIFT(LINE_SHIFT), .TX_OFF(TX_OFFSET)) u_vec (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack       (ack),
      .dir       (dir),
      .found_rx  (found_rx),
      .idx_rx    (idx_rx),
      .found_tx  (found_tx),
      .idx_tx    (idx_tx),
      .base      (vec_base),
      .vec_valid (vec_valid),
      .vec_out   (vec_out)
   );

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
   parameter int MAX_LINES  = 16,
   parameter int NUM_LINES  = 16,
   parameter int VEC_W      = 16,
   parameter int LINE_SHIFT = 3,
   parameter int TX_OFFSET  = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [MAX_LINES-1:0] rx_set,
   input logic [MAX_LINES-1:0] tx_set,
   input logic [MAX_LINES-1:0] line_rst,
   input logic [VEC_W-1:0]     vec_base,
   input logic                 ack,
   input logic                 ack_tx,
   input logic                 rx_irq,
   input logic                 tx_irq,
   input logic                 vec_valid,
   input logic [VEC_W-1:0]     vec_out
);

   localparam logic [MAX_LINES-1:0] LIVE = {MAX_LINES{1'b1}} >> (MAX_LINES - NUM_LINES);
   localparam logic [VEC_W-1:0]     LOW_MASK = VEC_W'((1 << LINE_SHIFT) - 1);

   AST_SET_RAISES_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rx_set & LIVE & ~line_rst)) |=> rx_irq);  // R1
   AST_SET_RAISES_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (|(tx_set & LIVE & ~line_rst)) |=> tx_irq);  // R1
   AST_LINE_RST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      ((&(line_rst | ~LIVE)) && rx_set == '0 && tx_set == '0) |=> (!rx_irq && !tx_irq));  // R7
   AST_EMPTY_RX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !ack_tx && !rx_irq) |=> (vec_out == '0));  // R6
   AST_EMPTY_TX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_tx && !tx_irq) |=> (vec_out == '0));  // R6
   AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> vec_valid);  // R9
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> !vec_valid);  // R9
   AST_RX_VEC_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !ack_tx && rx_irq) |=> (((vec_out - $past(vec_base)) & LOW_MASK) == '0));  // R4
   AST_TX_VEC_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_tx && tx_irq) |=> (((vec_out - $past(vec_base)) & LOW_MASK) == VEC_W'(TX_OFFSET)));  // R4
   AST_DEAD_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_irq && (rx_set & LIVE) == '0) |=> !rx_irq);  // R10

endmodule

bind irq_vector_arbiter irqv_checker #(
   .MAX_LINES  (MAX_LINES),
   .NUM_LINES  (NUM_LINES),
   .VEC_W      (VEC_W),
   .LINE_SHIFT (LINE_SHIFT),
   .TX_OFFSET  (TX_OFFSET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_set    (rx_set),
   .tx_set    (tx_set),
   .line_rst  (line_rst),
   .vec_base  (vec_base),
   .ack       (ack),
   .ack_tx    (ack_tx),
   .rx_irq    (rx_irq),
   .tx_irq    (tx_irq),
   .vec_valid (vec_valid),
   .vec_out   (vec_out)
);

// File: tb/irq_vector_arbiter_test.sv
`timescale 1ns/1ps
module irq_vector_arbiter_test;

   localparam int ML = 16;
   localparam int NL = 12;
   localparam logic [15:0] ACT = 16'h0FFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] rx_set = '0, rx_clr = '0, tx_set = '0, tx_clr = '0, line_rst = '0;
   logic [15:0] vec_base = 16'h00C0;
   logic        ack = 1'b0, ack_tx = 1'b0;
   logic        rx_irq, tx_irq, vec_valid;
   logic [15:0] vec_out;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic [15:0] mrx = '0, mtx = '0;
   logic [15:0] expq[$];
   string       tagq[$];

   always #10 clk = ~clk;  // 50 MHz

   irq_vector_arbiter #(.MAX_LINES(ML), .NUM_LINES(NL), .VEC_W(16)) uut (
      .clk(clk), .rst_n(rst_n),
      .rx_set(rx_set), .rx_clr(rx_clr), .tx_set(tx_set), .tx_clr(tx_clr),
      .line_rst(line_rst), .vec_base(vec_base), .ack(ack), .ack_tx(ack_tx),
      .rx_irq(rx_irq), .tx_irq(tx_irq), .vec_valid(vec_valid), .vec_out(vec_out)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one driven cycle; the scoreboard learns the expected vector of an acknowledge
   task automatic drive(input logic [15:0] rs, rc, ts, tc, lr, input bit ak, input bit tx, input string tag);
      logic [15:0] sel, oh;
      int          idx;
      bit          f;
      rx_set = rs; rx_clr = rc; tx_set = ts; tx_clr = tc; line_rst = lr;
      ack = ak; ack_tx = tx;
      oh = '0;
      if (ak) begin
         sel = tx ? mtx : mrx;
         f = 0; idx = 0;
         for (int i = 15; i >= 0; i--) if (sel[i]) begin f = 1; idx = i; end
         if (f) oh[idx] = 1'b1;
         expq.push_back(f ? (vec_base + 16'(idx * 8) + (tx ? 16'd4 : 16'd0)) : 16'd0);
         tagq.push_back(tag);
      end
      @(posedge clk); #1;
      mrx = ((mrx & ~rc & ~((ak && !tx) ? oh : 16'h0)) | rs) & ~lr & ACT;
      mtx = ((mtx & ~tc & ~((ak &&  tx) ? oh : 16'h0)) | ts) & ~lr & ACT;
      rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0; line_rst = '0;
      ack = 1'b0; ack_tx = 1'b0;
   endtask

   task automatic chk_irq(input string tag);
      check({rx_irq, tx_irq} == {|mrx, |mtx}, tag, {30'd0, rx_irq, tx_irq}, {30'd0, |mrx, |mtx});
   endtask

   // monitor: pop the scoreboard whenever a vector is presented
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         if (expq.size() == 0) begin
            check(1'b0, "R9 unexpected vec_valid", 32'd1, 32'd0);
         end else begin
            logic [15:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(vec_out == e, t, {16'd0, vec_out}, {16'd0, e});
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      check({rx_irq, tx_irq, vec_valid} == 3'b000, "R1 reset state", {29'd0, rx_irq, tx_irq, vec_valid}, 32'd0);

      // R6 empty acknowledges in both directions
      drive('0, '0, '0, '0, '0, 1, 0, "R6 empty rx ack");
      drive('0, '0, '0, '0, '0, 1, 1, "R6 empty tx ack");

      // R1 a single set raises only its direction
      drive(16'h0020, '0, '0, '0, '0, 0, 0, "");
      chk_irq("R1 rx set line 5");

      // R3 R5 lowest first, other direction untouched
      drive(16'h0208, '0, 16'h0080, '0, '0, 0, 0, "");
      chk_irq("R1 rx+tx set");
      drive('0, '0, '0, '0, '0, 1, 0, "R3 rx ack picks line 3");
      chk_irq("R5 after first ack");
      drive('0, '0, '0, '0, '0, 1, 0, "R3 rx ack picks line 5");
      drive('0, '0, '0, '0, '0, 1, 0, "R3 rx ack picks line 9");
      chk_irq("R5 rx drained tx kept");
      drive('0, '0, '0, '0, '0, 1, 1, "R4 tx vector line 7");
      chk_irq("R5 tx drained");

      // R2 clears, master drops only after the last one
      drive(16'h0014, '0, '0, '0, '0, 0, 0, "");
      drive('0, 16'h0004, '0, '0, '0, 0, 0, "");
      chk_irq("R2 one bit left");
      drive('0, 16'h0010, '0, '0, '0, 0, 0, "");
      chk_irq("R2 last bit cleared");

      // R8 set beats clear, set beats acknowledge clearing
      drive(16'h0040, 16'h0040, '0, '0, '0, 0, 0, "");
      chk_irq("R8 set and clear same cycle");
      drive('0, '0, '0, '0, '0, 1, 0, "R8 line 6 still pending");
      drive('0, '0, 16'h0001, '0, '0, 0, 0, "");
      drive('0, '0, 16'h0001, '0, '0, 1, 1, "R8 tx ack line 0 with set");
      drive('0, '0, '0, '0, '0, 1, 1, "R8 tx line 0 re-served");
      chk_irq("R8 tx empty after re-serve");

      // R7 line reset clears both directions and beats a set
      drive(16'h0100, '0, 16'h0100, '0, '0, 0, 0, "");
      drive('0, '0, '0, '0, 16'h0100, 0, 0, "");
      chk_irq("R7 line reset clears both");
      drive(16'h0400, '0, 16'h0400, '0, 16'h0400, 0, 0, "");
      chk_irq("R7 reset beats set");
      drive('0, '0, '0, '0, '0, 1, 0, "R7 nothing left after reset");

      // R10 inactive lines ignored
      drive(16'hF000, '0, 16'hF000, '0, '0, 0, 0, "");
      chk_irq("R10 inactive sets ignored");
      drive('0, '0, '0, '0, '0, 1, 1, "R10 no inactive line served");

      // R4 base taken from the acknowledge cycle, highest active line
      drive(16'h0800, '0, 16'h0800, '0, '0, 0, 0, "");
      vec_base = 16'h0100;
      drive('0, '0, '0, '0, '0, 1, 0, "R4 rx vector new base line 11");
      vec_base = 16'h0200;
      drive('0, '0, '0, '0, '0, 1, 1, "R4 tx vector new base line 11");
      vec_base = 16'h00C0;

      // R3 full sweep of all active lines, both directions
      drive(16'hFFFF, '0, 16'hFFFF, '0, '0, 0, 0, "");
      chk_irq("R1 all lines set");
      for (int k = 0; k < NL; k++) begin
         drive('0, '0, '0, '0, '0, 1, k[0], "R3 sweep ack");
         drive('0, '0, '0, '0, '0, 1, ~k[0], "R3 sweep ack other dir");
      end
      chk_irq("R2 all drained");

      @(posedge clk); #1;
      check(vec_valid == 1'b0, "R9 valid drops after ack", {31'd0, vec_valid}, 32'd0);
      check(expq.size() == 0, "R9 every ack produced a vector", expq.size(), 32'd0);
      finish_run();
   end

endmodule